// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a two-bank, word-wide flash array model and turns a stream of synchronous write cycles into operation requests. Each command opens with a fixed two-word unlock prefix. A third key word then selects word program, entry to identification mode, exit from identification mode, or an erase prefix. The erase prefix needs a second unlock pair and a final word that picks whole-bank, block or sector erase. The decoder reports a finished command as a single-cycle start pulse. The pulse carries the operation code, the bank, the target address and the program data. The decoder also keeps one identification-mode flag per bank.

The bank is taken from the top address bit of the last word of each sequence. A word that breaks the expected pattern silently drops the decoder back to read mode. A companion timer block drives a per-bank busy input, and while any bank is busy every write is ignored. An active-low protect input blocks all requests that target the lower bank. Cycles with the write strobe low are read cycles and leave the sequence untouched.

The write bus has no back-pressure. The decoder takes one word in every cycle where the strobe is high. The start outputs are a plain pulse with no handshake, so the timer block must capture the request in the cycle the pulse is high.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the start pulse is low, both identification flags are 0 and the decoder expects the first unlock word.
- R2: The unlock prefix is data 0xAA at address 0x5555, followed by data 0x55 at address 0x2AAA. Only address bits 14..0 and data bits 7..0 of command words are compared. Address bits 20..15 and data bits 15..8 have no effect on the decoding.
- R3: After the prefix, key 0xA0 at address 0x5555 arms word program. The next write completes it at any address. On the clock edge that samples this write, start_o rises with start_op=0, start_bank=address bit 20 of that write, start_addr=its bits 19..0 and start_data=its full 16-bit data.
- R4: After the prefix, key 0x90 at 0x5555 sets the identification flag of the bank given by address bit 20 of that key word, and key 0xF0 clears it. Bit 0 of id_mode belongs to bank bit 0. No start pulse is produced.
- R5: After the prefix, key 0x80 at 0x5555 must be followed by 0xAA at 0x5555, then 0x55 at 0x2AAA, then a sixth word. The sixth word selects one of three erases. Sixth data 0x10 at address 0x5555 gives bank erase, with start_op=3 and start_addr=0. Sixth data 0x50 gives block erase, with start_op=2 and start_addr = bits 19..15 of the sixth address followed by zeros. Sixth data 0x30 gives sector erase, with start_op=1 and start_addr = bits 19..11 followed by zeros. Erase start_data is 0, and the bank is bit 20 of the sixth word.
- R6: A wrong address or data value in any compared word returns the decoder to the first-unlock state with no start and no flag change. The wrong word does not count as a new first word, even if it is 0xAA at 0x5555.
- R7: A cycle with wr_en low neither advances nor resets the sequence.
- R8: While any bit of bank_busy is high, a write has no effect: the sequence position and the identification flags hold and no start is produced.
- R9: While wp_n is low, a completed program or erase of any kind aimed at bank bit 0 produces no start, and the sequence still returns to idle. The same requests for bank bit 1 proceed. Identification commands are unaffected.
- R10: start_o is high for exactly one clock per completed command. The other start outputs are registered with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; a word is taken each cycle it is high |
| wr_addr | input | 21 | Write address; bit 20 selects the bank |
| wr_data | input | 16 | Write data |
| bank_busy | input | 2 | Per-bank operation-in-progress from the timer block |
| wp_n | input | 1 | Active-low protect for bank 0 |
| start_o | output | 1 | One-cycle request pulse |
| start_op | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 bank erase |
| start_bank | output | 1 | Target bank |
| start_addr | output | 20 | Target word, block or sector base address |
| start_data | output | 16 | Program data (0 for erase) |
| id_mode | output | 2 | Identification-mode flag per bank |

## Verification
The bench targets junk in the ignored address and data bits. A decoder that compared too many bits would abort those sequences. It repeats the first unlock word where the second belongs; a design that restarted on it would accept a command one word too early. It asserts busy in the middle of a sequence and then finishes the sequence after busy drops. A design that reset its position on a busy write would lose the command, and one that advanced would fire on the wrong word. It also issues bank-0 commands under protect and read gaps inside sequences, where a faulty design would either start a blocked operation or lose its place.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int KEY_W  = 15;
  localparam int CODE_W = 8;
  localparam int BANKS  = 2;

  localparam logic [KEY_W-1:0]  KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0]  KEY_ADDR_B = 15'h2AAA;
  localparam logic [CODE_W-1:0] UNLOCK_A   = 8'hAA;
  localparam logic [CODE_W-1:0] UNLOCK_B   = 8'h55;
  localparam logic [CODE_W-1:0] KEY_PROG   = 8'hA0;
  localparam logic [CODE_W-1:0] KEY_ID_ON  = 8'h90;
  localparam logic [CODE_W-1:0] KEY_ID_OFF = 8'hF0;
  localparam logic [CODE_W-1:0] KEY_ERASE  = 8'h80;
  localparam logic [CODE_W-1:0] ERS_BANK   = 8'h10;
  localparam logic [CODE_W-1:0] ERS_BLOCK  = 8'h50;
  localparam logic [CODE_W-1:0] ERS_SECT   = 8'h30;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_BANK  = 2'd3
  } fcd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_UNL1  = 3'd1,
    ST_UNL2  = 3'd2,
    ST_PROG  = 3'd3,
    ST_ERS_A = 3'd4,
    ST_ERS_B = 3'd5,
    ST_ERS_C = 3'd6
  } fcd_state_e;

  typedef struct packed {
    logic first;
    logic second;
    logic at_key;
  } fcd_cls_t;
endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
(
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [CODE_W-1:0] code,
  output fcd_cls_t          cls
);
  always_comb begin
    cls.at_key = (key_addr == KEY_ADDR_A);
    cls.first  = cls.at_key && (code == UNLOCK_A);
    cls.second = (key_addr == KEY_ADDR_B) && (code == UNLOCK_B);
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  fcd_cls_t          cls,
  input  logic [CODE_W-1:0] code,
  output logic              fire,
  output fcd_op_e           fire_op,
  output logic              id_set,
  output logic              id_clr
);
  fcd_state_e state, nxt;

  always_comb begin
    nxt     = state;
    fire    = 1'b0;
    fire_op = OP_PROG;
    id_set  = 1'b0;
    id_clr  = 1'b0;
    if (accept) begin
      case (state)
        ST_IDLE:  nxt = cls.first  ? ST_UNL1 : ST_IDLE;
        ST_UNL1:  nxt = cls.second ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          nxt = ST_IDLE;
          if (cls.at_key) begin
            case (code)
              KEY_PROG:   nxt = ST_PROG;
              KEY_ID_ON:  id_set = 1'b1;
              KEY_ID_OFF: id_clr = 1'b1;
              KEY_ERASE:  nxt = ST_ERS_A;
              default:    nxt = ST_IDLE;
            endcase
          end
        end
        ST_PROG: begin
          fire    = 1'b1;
          fire_op = OP_PROG;
          nxt     = ST_IDLE;
        end
        ST_ERS_A: nxt = cls.first  ? ST_ERS_B : ST_IDLE;
        ST_ERS_B: nxt = cls.second ? ST_ERS_C : ST_IDLE;
        ST_ERS_C: begin
          nxt = ST_IDLE;
          case (code)
            ERS_BANK: begin
              fire    = cls.at_key;
              fire_op = OP_BANK;
            end
            ERS_BLOCK: begin
              fire    = 1'b1;
              fire_op = OP_BLOCK;
            end
            ERS_SECT: begin
              fire    = 1'b1;
              fire_op = OP_SECT;
            end
            default: fire = 1'b0;
          endcase
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(state)); // R7
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state == ST_UNL1 && !cls.second) |=> state == ST_IDLE); // R6
endmodule

// File: rtl/fcd_issue.sv
module fcd_issue
  import fcd_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int SECT_LSB  = 11,
  parameter int BLK_LSB   = 15,
  parameter bit PROT_BANK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  fcd_op_e           fire_op,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              start_o,
  output logic [1:0]        start_op,
  output logic              start_bank,
  output logic [ADDR_W-2:0] start_addr,
  output logic [DATA_W-1:0] start_data
);
  localparam int LOW_W = ADDR_W - 1;

  logic             bank_sel;
  logic             allowed;
  logic [LOW_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;

  assign bank_sel = addr[ADDR_W-1];
  assign allowed  = wp_n || (bank_sel != PROT_BANK);

  always_comb begin
    tgt_data = '0;
    case (fire_op)
      OP_PROG: begin
        tgt_addr = addr[LOW_W-1:0];
        tgt_data = data;
      end
      OP_SECT:  tgt_addr = {addr[LOW_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
      OP_BLOCK: tgt_addr = {addr[LOW_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
      default:  tgt_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o    <= 1'b0;
      start_op   <= OP_PROG;
      start_bank <= 1'b0;
      start_addr <= '0;
      start_data <= '0;
    end else begin
      start_o <= fire && allowed;
      if (fire && allowed) begin
        start_op   <= fire_op;
        start_bank <= bank_sel;
        start_addr <= tgt_addr;
        start_data <= tgt_data;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R10
  AST_PROTECT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && start_bank == PROT_BANK) |-> $past(wp_n)); // R9
  AST_ERASE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && start_op != OP_PROG) |-> start_data == '0); // R5
endmodule

// File: rtl/fcd_idmode.sv
module fcd_idmode
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_set,
  input  logic             id_clr,
  input  logic             bank,
  output logic [BANKS-1:0] id_mode
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == b[0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              id_mode[b] <= 1'b0;
      else if (id_set && hit)  id_mode[b] <= 1'b1;
      else if (id_clr && hit)  id_mode[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BANKS-1:0]  bank_busy,
  input  logic              wp_n,
  output logic              start_o,
  output logic [1:0]        start_op,
  output logic              start_bank,
  output logic [ADDR_W-2:0] start_addr,
  output logic [DATA_W-1:0] start_data,
  output logic [BANKS-1:0]  id_mode
);
  logic     accept;
  fcd_cls_t cls;
  logic     fire, id_set, id_clr;
  fcd_op_e  fire_op;

  assign accept = wr_en && (bank_busy == '0);

  fcd_classify u_cls (
    .key_addr (wr_addr[KEY_W-1:0]),
    .code     (wr_data[CODE_W-1:0]),
    .cls      (cls)
  );

  fcd_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .cls     (cls),
    .code    (wr_data[CODE_W-1:0]),
    .fire    (fire),
    .fire_op (fire_op),
    .id_set  (id_set),
    .id_clr  (id_clr)
  );

  fcd_issue #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_LSB (SECT_LSB),
    .BLK_LSB  (BLK_LSB)
  ) u_iss (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_op    (fire_op),
    .wp_n       (wp_n),
    .addr       (wr_addr),
    .data       (wr_data),
    .start_o    (start_o),
    .start_op   (start_op),
    .start_bank (start_bank),
    .start_addr (start_addr),
    .start_data (start_data)
  );

  fcd_idmode u_id (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_set  (id_set),
    .id_clr  (id_clr),
    .bank    (wr_addr[ADDR_W-1]),
    .id_mode (id_mode)
  );

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_busy) |=> !start_o); // R8
  AST_BUSY_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_busy) |=> $stable(id_mode)); // R8
  AST_READ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !start_o); // R7
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [20:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  bank_busy = '0;
  logic        wp_n = 1'b1;
  logic        start_o;
  logic [1:0]  start_op;
  logic        start_bank;
  logic [19:0] start_addr;
  logic [15:0] start_data;
  logic [1:0]  id_mode;

  always #10 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_busy(bank_busy), .wp_n(wp_n),
    .start_o(start_o), .start_op(start_op), .start_bank(start_bank),
    .start_addr(start_addr), .start_data(start_data), .id_mode(id_mode)
  );

  int vectors = 0;
  int miscompares = 0;
  int ms = 0;
  logic [1:0]  m_id = '0;
  logic        e_start = 1'b0;
  logic [1:0]  e_op = '0;
  logic        e_bank = 1'b0;
  logic [19:0] e_addr = '0;
  logic [15:0] e_data = '0;

  function automatic logic [19:0] erase_base(input logic [1:0] op, input logic [20:0] a);
    case (op)
      2'd1:    return {a[19:11], 11'b0};
      2'd2:    return {a[19:15], 15'b0};
      default: return 20'b0;
    endcase
  endfunction

  task automatic fire_model(input logic [1:0] op, input logic [20:0] a,
                            input logic [15:0] d, input logic wp);
    if (wp || a[20]) begin
      e_start = 1'b1;
      e_op    = op;
      e_bank  = a[20];
      e_addr  = (op == 2'd0) ? a[19:0] : erase_base(op, a);
      e_data  = (op == 2'd0) ? d : 16'h0;
    end
  endtask

  task automatic model(input logic [20:0] a, input logic [15:0] d, input logic we,
                       input logic [1:0] bz, input logic wp);
    logic u1, u2, k;
    e_start = 1'b0;
    if (!we || bz != 2'b00) return;
    k  = (a[14:0] == 15'h5555);
    u1 = k && d[7:0] == 8'hAA;
    u2 = (a[14:0] == 15'h2AAA) && d[7:0] == 8'h55;
    case (ms)
      0: ms = u1 ? 1 : 0;
      1: ms = u2 ? 2 : 0;
      2: begin
        ms = 0;
        if (k) begin
          if (d[7:0] == 8'hA0) ms = 3;
          else if (d[7:0] == 8'h90) m_id[a[20]] = 1'b1;
          else if (d[7:0] == 8'hF0) m_id[a[20]] = 1'b0;
          else if (d[7:0] == 8'h80) ms = 4;
        end
      end
      3: begin ms = 0; fire_model(2'd0, a, d, wp); end
      4: ms = u1 ? 5 : 0;
      5: ms = u2 ? 6 : 0;
      default: begin
        ms = 0;
        if (d[7:0] == 8'h10 && k) fire_model(2'd3, a, d, wp);
        else if (d[7:0] == 8'h50) fire_model(2'd2, a, d, wp);
        else if (d[7:0] == 8'h30) fire_model(2'd1, a, d, wp);
      end
    endcase
  endtask

  task automatic check(input string tag);
    vectors++;
    if (start_o !== e_start) begin
      miscompares++;
      $display("FAIL %s start_o actual=%0b expected=%0b", tag, start_o, e_start);
    end else if (e_start) begin
      if ({start_op, start_bank, start_addr, start_data} !== {e_op, e_bank, e_addr, e_data}) begin
        miscompares++;
        $display("FAIL %s request actual=%0d/%0b/%h/%h expected=%0d/%0b/%h/%h", tag,
                 start_op, start_bank, start_addr, start_data, e_op, e_bank, e_addr, e_data);
      end
    end
    if (id_mode !== m_id) begin
      miscompares++;
      $display("FAIL %s id_mode actual=%b expected=%b", tag, id_mode, m_id);
    end
  endtask

  task automatic apply(input logic [20:0] a, input logic [15:0] d, input logic we,
                       input logic [1:0] bz, input logic wp, input string tag);
    wr_addr = a; wr_data = d; wr_en = we; bank_busy = bz; wp_n = wp;
    @(posedge clk);
    model(a, d, we, bz, wp);
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d, input logic wp, input string tag);
    apply(a, d, 1'b1, 2'b00, wp, tag);
  endtask

  task automatic idle(input string tag);
    apply(21'h0, 16'h0, 1'b0, 2'b00, 1'b1, tag);
  endtask

  task automatic prefix(input logic wp, input string tag);
    wr({6'h2B, 15'h5555}, 16'h7EAA, wp, tag);
    wr({6'h11, 15'h2AAA}, 16'hC355, wp, tag);
  endtask

  task automatic erase6(input logic [7:0] kind, input logic [20:0] a, input logic wp, input string tag);
    prefix(wp, tag);
    wr({1'b0, 5'h0, 15'h5555}, 16'h0080, wp, tag);
    prefix(wp, tag);
    wr(a, {8'h00, kind}, wp, tag);
  endtask

  task automatic random_cmd();
    logic [20:0] sa[6];
    logic [15:0] sd[6];
    logic [1:0]  bz;
    logic        wp;
    int n, kind;
    string tag;
    kind = $urandom % 6;
    wp = ($urandom % 3) != 0;
    for (int i = 0; i < 6; i++) begin
      sa[i] = {$urandom % 64, ((i % 3) == 1) ? 15'h2AAA : 15'h5555};
      sd[i] = {8'($urandom), ((i % 3) == 1) ? 8'h55 : 8'hAA};
    end
    n = 3;
    case (kind)
      0: begin sd[2][7:0] = 8'hA0; n = 4; sa[3] = 21'($urandom); sd[3] = 16'($urandom); tag = "R3"; end
      1: begin sd[2][7:0] = 8'h90; tag = "R4"; end
      2: begin sd[2][7:0] = 8'hF0; tag = "R4"; end
      default: begin
        sd[2][7:0] = 8'h80; n = 6; tag = "R5";
        sa[5] = 21'($urandom);
        sd[5][7:0] = (kind == 3) ? 8'h10 : (kind == 4) ? 8'h50 : 8'h30;
        if (kind == 3 && ($urandom % 2) == 0) sa[5][14:0] = 15'h5555;
      end
    endcase
    if ($urandom % 5 == 0) begin
      int idx = $urandom % n;
      sd[idx][0] = ~sd[idx][0];
      tag = "R6";
    end
    for (int i = 0; i < n; i++) begin
      if ($urandom % 4 == 0) idle("R7");
      bz = ($urandom % 12 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      apply(sa[i], sd[i], 1'b1, bz, wp, (bz != 0) ? "R8" : (!wp ? "R9" : tag));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    idle("R1");

    // R2 / R3: program with junk in ignored bits
    prefix(1'b1, "R2");
    wr({1'b0, 5'h1F, 15'h5555}, 16'hFFA0, 1'b1, "R3");
    wr(21'h0ABCDE, 16'h1234, 1'b1, "R3");
    idle("R10");

    // R7: read gaps inside a sequence
    wr(21'h005555, 16'h00AA, 1'b1, "R7");
    idle("R7"); idle("R7"); idle("R7");
    wr(21'h002AAA, 16'h0055, 1'b1, "R7");
    idle("R7");
    wr(21'h105555, 16'h00A0, 1'b1, "R7");
    idle("R7");
    wr(21'h1FFFFF, 16'hBEEF, 1'b1, "R7");

    // R4: identification flags
    prefix(1'b1, "R4"); wr(21'h105555, 16'h0090, 1'b1, "R4");
    prefix(1'b1, "R4"); wr(21'h005555, 16'h0090, 1'b1, "R4");
    prefix(1'b1, "R4"); wr(21'h105555, 16'h00F0, 1'b1, "R4");
    prefix(1'b1, "R4"); wr(21'h005555, 16'h00F0, 1'b1, "R4");

    // R5: the three erases
    erase6(8'h30, 21'h1ABCDE, 1'b1, "R5");
    erase6(8'h50, 21'h0ABCDE, 1'b1, "R5");
    erase6(8'h10, 21'h105555, 1'b1, "R5");
    erase6(8'h10, 21'h104444, 1'b1, "R5");

    // R6: abort and no restart on a repeated first word
    wr(21'h005555, 16'h00AA, 1'b1, "R6");
    wr(21'h002AAA, 16'h0056, 1'b1, "R6");
    wr(21'h005555, 16'h00AA, 1'b1, "R6");
    wr(21'h005555, 16'h00AA, 1'b1, "R6");
    wr(21'h002AAA, 16'h0055, 1'b1, "R6");
    wr(21'h005555, 16'h00A0, 1'b1, "R6");
    wr(21'h012345, 16'h5A5A, 1'b1, "R6");
    prefix(1'b1, "R6"); wr(21'h005555, 16'h00A0, 1'b1, "R6");
    wr(21'h012345, 16'h5A5A, 1'b1, "R6");

    // R8: busy writes are ignored, sequence resumes afterwards
    prefix(1'b1, "R8");
    apply(21'h005555, 16'h00A0, 1'b1, 2'b10, 1'b1, "R8");
    apply(21'h005555, 16'h0090, 1'b1, 2'b01, 1'b1, "R8");
    wr(21'h005555, 16'h00A0, 1'b1, "R8");
    apply(21'h033333, 16'h7777, 1'b1, 2'b11, 1'b1, "R8");
    wr(21'h033333, 16'h7777, 1'b1, "R8");

    // R9: protect blocks bank 0 only
    prefix(1'b0, "R9"); wr(21'h005555, 16'h00A0, 1'b0, "R9");
    wr(21'h000100, 16'h4444, 1'b0, "R9");
    erase6(8'h30, 21'h1ABCDE, 1'b0, "R9");
    erase6(8'h10, 21'h005555, 1'b0, "R9");
    erase6(8'h10, 21'h105555, 1'b0, "R9");
    erase6(8'h50, 21'h088000, 1'b0, "R9");
    prefix(1'b0, "R9"); wr(21'h005555, 16'h0090, 1'b0, "R9");
    prefix(1'b0, "R9"); wr(21'h005555, 16'h00F0, 1'b0, "R9");

    for (int i = 0; i < 400; i++) random_cmd();
    idle("R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule